// File: doc/BRIEF.md
# Multi-Resolution One-Shot Timer

This block is a small timer that a processor reaches over a narrow 8-bit I/O bus. It has three count registers. Writing a value to one of them loads the value and starts a single countdown. The register chosen sets the length of each step: a microsecond, a millisecond or a second. When the count reaches zero the timer stops and stays idle until the next write. Software polls a status byte, readable at every register address, to learn whether the wait is over.

The time steps come from a chain of three prescalers driven by the system clock. The clock frequency and the two decade ratios are parameters, so a test build can shrink a second to a few hundred cycles. Every start write clears the whole chain. The first step therefore arrives one full unit after the write, and a count of N never ends before N units have passed. The decode that drives the chip-select from the upper address bits belongs to the surrounding bus and is not part of this block.

Top module: `tmr_oneshot`

## Requirements
- R1: A write (sel_i=1, wr_stb_i=1) to register address 0 with count N>0 sets status bit 0 from the next clock edge. Bit 0 clears at exactly the edge N×CYC_PER_US cycles after the write edge, where CYC_PER_US = CLK_FREQ_HZ/1,000,000.
- R2: A write to register address 1 with count N>0 behaves as R1, with the busy time equal to N×CYC_PER_US×US_PER_MS cycles.
- R3: A write to register address 2 with count N>0 behaves as R1, with the busy time equal to N×CYC_PER_US×US_PER_MS×MS_PER_S cycles.
- R4: A write to register address 3 has no effect. It neither starts an idle timer nor changes when a running count ends.
- R5: A write strobe while sel_i is 0 has no effect on the timer.
- R6: A start write with count 0 leaves status bit 0 at 0 after the write edge, and it aborts any count that is running.
- R7: A start write while a count is running discards that count. The new count and resolution run from a cleared prescaler chain, with the busy time measured from the new write edge.
- R8: rd_data_o carries the status at every value of reg_addr_i. Bit 0 is 1 while a count runs, and bits DATA_W-1 to 1 are 0.
- R9: rst_n_i low clears the count, the busy flag and all prescalers at once, and the timer stays idle after reset is released.
- R10: After a count finishes, status bit 0 stays 0 until the next start write. The timer never reloads by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Block select from the bus address decode |
| wr_stb_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr_i | input | 2 | Register index: 0 µs, 1 ms, 2 s, 3 unused |
| wr_data_i | input | DATA_W | Count value to load |
| rd_data_o | output | DATA_W | Status byte; bit 0 is busy |

## Verification
The bench measures each countdown to the exact cycle, one cycle before and at the expected end. A design that did not clear the prescaler chain, or that counted one unit too many or too few, ends early or late and is caught.

A restart is issued part way through a unit, at a point where a prescaler left running would produce an early step. Zero-count writes check that busy is never raised and that a running count is aborted. Writes to the unused address and unselected writes are issued during a running count, so a design that restarted or extended the count would end at the wrong cycle.

Reset is asserted in the middle of a count. After release, the bench watches past the old end time so that a reload or a stale count would show up.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Register index doubles as the resolution code; index 3 is unused.
   typedef enum logic [1:0] {
      RES_US   = 2'd0,
      RES_MS   = 2'd1,
      RES_SEC  = 2'd2,
      RES_NONE = 2'd3
   } tmr_res_e;

   localparam int NUM_STAGES = 3;
   localparam int HZ_PER_MHZ = 1000000;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              sel_i,
   input  logic              wr_stb_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              start_o,
   output tmr_res_e          res_o,
   output logic [DATA_W-1:0] val_o
);
   tmr_res_e addr_res;

   always_comb begin
      addr_res = tmr_res_e'(reg_addr_i);
      start_o  = sel_i && wr_stb_i && (addr_res != RES_NONE);
      res_o    = addr_res;
      val_o    = wr_data_i;
   end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clr_i,
   input  logic tick_i,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("tmr_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      logic unused_pins;
      assign unused_pins = ^{clk_i, rst_n_i, clr_i};
      assign tick_o = tick_i;
   end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            cnt_q <= '0;
         end else if (clr_i) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign tick_o = tick_i && (cnt_q == LAST);

      // R7: the phase counter never leaves its range
      assert_phase_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         cnt_q <= LAST);
      // R7: a clear always restarts the phase from zero
      assert_clear_restarts_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         clr_i |=> (cnt_q == '0));
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              start_i,
   input  tmr_res_e          res_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              tick_us_i,
   input  logic              tick_ms_i,
   input  logic              tick_s_i,
   output logic              busy_o
);
   logic [DATA_W-1:0] cnt_q;
   logic              busy_q;
   tmr_res_e          res_q;
   logic              step;

   always_comb begin
      unique case (res_q)
         RES_US:  step = tick_us_i;
         RES_MS:  step = tick_ms_i;
         RES_SEC: step = tick_s_i;
         default: step = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         res_q  <= RES_US;
      end else if (start_i) begin
         cnt_q  <= val_i;
         busy_q <= (val_i != '0);
         res_q  <= res_i;
      end else if (busy_q && step) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == DATA_W'(1)) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;

   // R1: a nonzero load raises busy on the next edge
   assert_load_sets_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && val_i != '0) |=> busy_q);
   // R6: a zero load leaves the timer idle
   assert_zero_load_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (start_i && val_i == '0) |=> !busy_q);
   // R10: an idle timer stays idle without a start
   assert_no_self_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!busy_q && !start_i) |=> !busy_q);
   // R1: the count holds between steps
   assert_hold_between_steps_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (busy_q && !step && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_oneshot.sv
module tmr_oneshot
   import tmr_pkg::*;
#(
   parameter int CLK_FREQ_HZ = 50000000,
   parameter int US_PER_MS   = 1000,
   parameter int MS_PER_S    = 1000,
   parameter int DATA_W      = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              sel_i,
   input  logic              wr_stb_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int CYC_PER_US = CLK_FREQ_HZ / HZ_PER_MHZ;
   localparam int STAGE_DIV [NUM_STAGES] = '{CYC_PER_US, US_PER_MS, MS_PER_S};

   if (CLK_FREQ_HZ < HZ_PER_MHZ || (CLK_FREQ_HZ % HZ_PER_MHZ) != 0) begin : g_bad_clk
      $error("tmr_oneshot: CLK_FREQ_HZ must be a whole number of MHz");
   end
   if (US_PER_MS < 1 || MS_PER_S < 1) begin : g_bad_ratio
      $error("tmr_oneshot: decade ratios must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("tmr_oneshot: DATA_W must be at least 2");
   end

   logic              start;
   tmr_res_e          res;
   logic [DATA_W-1:0] val;
   logic              busy;
   logic              tick_chain [NUM_STAGES+1];

   tmr_decode #(.DATA_W(DATA_W)) u_decode (
      .sel_i      (sel_i),
      .wr_stb_i   (wr_stb_i),
      .reg_addr_i (reg_addr_i),
      .wr_data_i  (wr_data_i),
      .start_o    (start),
      .res_o      (res),
      .val_o      (val)
   );

   assign tick_chain[0] = 1'b1;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      tmr_prescale #(.DIV(STAGE_DIV[s])) u_pre (
         .clk_i   (clk_i),
         .rst_n_i (rst_n_i),
         .clr_i   (start),
         .tick_i  (tick_chain[s]),
         .tick_o  (tick_chain[s+1])
      );
   end

   tmr_count #(.DATA_W(DATA_W)) u_count (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .start_i   (start),
      .res_i     (res),
      .val_i     (val),
      .tick_us_i (tick_chain[1]),
      .tick_ms_i (tick_chain[2]),
      .tick_s_i  (tick_chain[3]),
      .busy_o    (busy)
   );

   assign rd_data_o = {{(DATA_W-1){1'b0}}, busy};

   // R4: the unused address cannot wake an idle timer
   assert_spare_addr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sel_i && wr_stb_i && reg_addr_i == 2'd3 && !rd_data_o[0]) |=> !rd_data_o[0]);
   // R5: an unselected strobe cannot wake an idle timer
   assert_unselected_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!sel_i && !rd_data_o[0]) |=> !rd_data_o[0]);
   // R7: a nonzero start write always leaves the timer running
   assert_restart_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sel_i && wr_stb_i && reg_addr_i != 2'd3 && wr_data_i != '0) |=> rd_data_o[0]);
endmodule

// File: tb/sim_tmr_oneshot.sv
module sim_tmr_oneshot;
   localparam int CLK_HZ = 4000000;
   localparam int UPM    = 5;
   localparam int MPS    = 4;
   localparam int U_US   = CLK_HZ / 1000000;
   localparam int U_MS   = U_US * UPM;
   localparam int U_S    = U_MS * MPS;

   typedef struct packed {
      logic [1:0] addr;
      logic [7:0] n;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'd3}, '{2'd1, 8'd2}, '{2'd2, 8'd1}, '{2'd0, 8'd1},
      '{2'd1, 8'd1}, '{2'd0, 8'd255}, '{2'd2, 8'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] din = 8'd0;
   logic [7:0] dout;
   int         total = 0;
   int         bad = 0;
   logic       done = 1'b0;

   always #2 clk = ~clk;

   tmr_oneshot #(.CLK_FREQ_HZ(CLK_HZ), .US_PER_MS(UPM), .MS_PER_S(MPS), .DATA_W(8)) u0 (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .sel_i      (sel),
      .wr_stb_i   (wr),
      .reg_addr_i (addr),
      .wr_data_i  (din),
      .rd_data_o  (dout)
   );

   function automatic int unit_of(input logic [1:0] a);
      case (a)
         2'd0:    return U_US;
         2'd1:    return U_MS;
         default: return U_S;
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] a);
      case (a)
         2'd0:    return "R1";
         2'd1:    return "R2";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the write edge.
   task automatic wrt(input logic [1:0] a, input logic [7:0] d, input logic s);
      sel = s; wr = 1'b1; addr = a; din = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; din = 8'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9", dout, 8'h00);                // reset state
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", dout, 8'h00);

      // table walk: exact end cycle per resolution
      for (int i = 0; i < NV; i++) begin
         int len;
         len = int'(VECS[i].n) * unit_of(VECS[i].addr);
         wrt(VECS[i].addr, VECS[i].n, 1'b1);
         repeat (len - 1) @(negedge clk);
         chk(tag_of(VECS[i].addr), dout, 8'h01);
         @(negedge clk);
         chk(tag_of(VECS[i].addr), dout, 8'h00);
         repeat (5) @(negedge clk);
         chk("R10", dout, 8'h00);          // no reload
      end

      // R8: status at every address while running
      wrt(2'd1, 8'd4, 1'b1);
      for (int a = 0; a < 4; a++) begin
         addr = 2'(a); sel = 1'b1;
         #1 chk("R8", dout, 8'h01);
      end
      sel = 1'b0; addr = 2'd0;
      @(negedge clk);

      // R6: zero count aborts a running count
      wrt(2'd0, 8'd0, 1'b1);
      chk("R6", dout, 8'h00);
      repeat (U_MS * 4) @(negedge clk);
      chk("R6", dout, 8'h00);
      // R8: idle status at every address
      for (int a = 0; a < 4; a++) begin
         addr = 2'(a); sel = 1'b1;
         #1 chk("R8", dout, 8'h00);
      end
      sel = 1'b0; addr = 2'd0;
      @(negedge clk);

      // R6: zero count from idle
      wrt(2'd2, 8'd0, 1'b1);
      chk("R6", dout, 8'h00);

      // R4: unused address from idle
      wrt(2'd3, 8'd9, 1'b1);
      chk("R4", dout, 8'h00);
      // R5: unselected write from idle
      wrt(2'd0, 8'd9, 1'b0);
      chk("R5", dout, 8'h00);

      // R4 and R5: ignored writes during a running count keep its end time
      wrt(2'd1, 8'd2, 1'b1);                 // 2*U_MS cycles
      repeat (9) @(negedge clk);
      wrt(2'd3, 8'd200, 1'b1);               // now 10 cycles in
      wrt(2'd2, 8'd200, 1'b0);               // now 11 cycles in
      repeat (2 * U_MS - 12) @(negedge clk);
      chk("R4", dout, 8'h01);
      @(negedge clk);
      chk("R4", dout, 8'h00);

      // R7: restart mid-unit from a long count to a short one
      wrt(2'd2, 8'd2, 1'b1);
      repeat (10) @(negedge clk);
      wrt(2'd0, 8'd3, 1'b1);
      repeat (3 * U_US - 1) @(negedge clk);
      chk("R7", dout, 8'h01);
      @(negedge clk);
      chk("R7", dout, 8'h00);
      repeat (2 * U_S) @(negedge clk);
      chk("R7", dout, 8'h00);                // old count gone

      // R7: restart short to longer, end measured from new write
      wrt(2'd0, 8'd5, 1'b1);
      repeat (6) @(negedge clk);
      wrt(2'd1, 8'd1, 1'b1);
      repeat (U_MS - 1) @(negedge clk);
      chk("R7", dout, 8'h01);
      @(negedge clk);
      chk("R7", dout, 8'h00);

      // R9: reset in the middle of a count
      wrt(2'd2, 8'd5, 1'b1);
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R9", dout, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (6 * U_S) @(negedge clk);
      chk("R9", dout, 8'h00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule